// File: doc/BRIEF.md
# Banked GPIO Port with Per-Pin Function Select

This block is a memory-mapped general-purpose I/O port for 54 pads. The pads are grouped into two 32-bit banks: pads 0 to 31 form bank 0, and pads 32 to 53 form bank 1. Each pad has a 3-bit function code. The code decides whether the pad is an input, a driven output, or is handed to one of six alternate peripherals. The pad-side outputs give the output value, the output enable, and a decoded alternate-function flag and slot number for the pad multiplexer.

Software changes the output value through two write-only strobe registers, one that forces bits high and one that forces bits low. A single pad can therefore be changed without first reading the register. The level registers return the pad inputs after a two-flop synchronizer. The output value of each pad is kept no matter what its function code is, so a value can be staged before the pad is made an output.

The register bus is a plain 32-bit write/read port with byte addresses. Read data is combinational from the current address. There is no wait state.

Top module: `gpio_bank_port`

## Requirements
- R1: After a synchronous active-low reset, the following all read 0: every function code, every output value, `pad_out`, `pad_oe`, `pad_alt_en` and `pad_alt_num`.
- R2: The function codes sit in six words at byte addresses 0x00, 0x04, ..., 0x14. Pad p sits in word p/10 at bits [(p%10)*3 +: 3]. A write to a word replaces those fields, and a read returns them. Bits 30 and 31, and the fields of pads 54 to 59, read 0.
- R3: Code 1 sets `pad_oe`. Code 0 is a plain input and sets neither `pad_oe` nor `pad_alt_en`. Codes 2 to 7 set `pad_alt_en`, with `pad_alt_num` (3 bits per pad) given by this map: 4→0, 5→1, 6→2, 7→3, 3→4, 2→5. `pad_alt_num` is 0 when the pad is not alternate.
- R4: A write to 0x1C (bank 0) or 0x20 (bank 1) sets the output value of every pad whose data bit is 1. Pads whose data bit is 0 are left unchanged. The change is visible on `pad_out` after the write edge.
- R5: A write to 0x28 (bank 0) or 0x2C (bank 1) clears the output value of every pad whose data bit is 1. Pads whose data bit is 0 are left unchanged.
- R6: A read of 0x34 returns pads 0 to 31 of `pad_in`, and a read of 0x38 returns pads 32 to 53 in bits 0 to 21. Each bit is the value sampled two rising edges earlier. Bits 22 to 31 of 0x38 read 0.
- R7: `pad_out` always shows the stored output value, whatever the function code. A value stored while a pad is an input appears with `pad_oe` as soon as the pad is switched to output.
- R8: The set and clear registers read 0. Reads of any other address outside R2 and R6 return 0. Writes to the level registers or to such addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pad_in | input | 54 | Pad input levels |
| pad_out | output | 54 | Stored output value per pad |
| pad_oe | output | 54 | Output enable (code 1) |
| pad_alt_en | output | 54 | Pad owned by an alternate function |
| pad_alt_num | output | 162 | Alternate slot per pad, 3 bits each |

## Verification
Two paths can act in the same cycle. In one, a pad input toggles while the bus is reading a level register. In the other, the bus writes a new function code or output value while the pad outputs are being observed. The bench drives random pad inputs on every cycle and random accesses across all mapped addresses and some unmapped ones, so reads of the level registers often land in the cycle where a pad changes. A behavioural model holds a two-entry history queue of the inputs and a per-pad code and value. Each cycle it predicts the read data and all pad outputs, and a read is judged correct only if it equals the input from two edges before.

// File: rtl/gpio_port_pkg.sv
// Shared definitions for the banked GPIO port.
// Assumes a 3-bit function code per pad; the alternate slot order is irregular
// and is captured here once so every user decodes it the same way.
package gpio_port_pkg;

    localparam int FN_W = 3;

    typedef enum logic [FN_W-1:0] {
        FN_INPUT  = 3'd0,
        FN_OUTPUT = 3'd1,
        FN_SLOT5  = 3'd2,
        FN_SLOT4  = 3'd3,
        FN_SLOT0  = 3'd4,
        FN_SLOT1  = 3'd5,
        FN_SLOT2  = 3'd6,
        FN_SLOT3  = 3'd7
    } pad_fn_e;

    // True when the code hands the pad to an alternate peripheral.
    function automatic logic fn_is_alt(input logic [FN_W-1:0] code);
        return code >= 3'd2;
    endfunction

    // Alternate slot number for a code; 0 when the code is not alternate.
    function automatic logic [FN_W-1:0] fn_alt_slot(input logic [FN_W-1:0] code);
        case (pad_fn_e'(code))
            FN_SLOT0: return 3'd0;
            FN_SLOT1: return 3'd1;
            FN_SLOT2: return 3'd2;
            FN_SLOT3: return 3'd3;
            FN_SLOT4: return 3'd4;
            FN_SLOT5: return 3'd5;
            default:  return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_fn_regs.sv
// Function-code storage: one FN_W field per pad, PER_WORD fields packed per
// bus word. Assumes one-hot word write strobes from the top-level decoder.
// Bits above the last field, and fields of absent pads, read zero.
module gpio_fn_regs
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS  = 54,
    parameter int DATA_W    = 32,
    parameter int PER_WORD  = 10,
    parameter int NUM_WORDS = (NUM_PINS + PER_WORD - 1) / PER_WORD
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_WORDS-1:0]        wr_word,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [NUM_PINS*FN_W-1:0]    fn_flat,
    output logic [NUM_WORDS*DATA_W-1:0] word_rd
);

    // Mask of bits that hold a real field in word w.
    function automatic logic [DATA_W-1:0] word_mask(input int w);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < PER_WORD; i++)
            if (w * PER_WORD + i < NUM_PINS)
                m[i*FN_W +: FN_W] = '1;
        return m;
    endfunction

    genvar p, w;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_pin
            localparam int WIDX  = p / PER_WORD;
            localparam int SHIFT = (p % PER_WORD) * FN_W;
            logic [FN_W-1:0] fn_q;
            // Hold the pad's code; load it when its word is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fn_q <= FN_INPUT;
                else if (wr_word[WIDX])
                    fn_q <= wr_data[SHIFT +: FN_W];
            end
            assign fn_flat[p*FN_W +: FN_W] = fn_q;
        end

        for (w = 0; w < NUM_WORDS; w++) begin : g_word
            localparam logic [DATA_W-1:0] WMASK = word_mask(w);
            // Assemble the readback word from the fields of its pads.
            always_comb begin
                word_rd[w*DATA_W +: DATA_W] = '0;
                for (int i = 0; i < PER_WORD; i++)
                    if (w * PER_WORD + i < NUM_PINS)
                        word_rd[w*DATA_W + i*FN_W +: FN_W] =
                            fn_flat[(w*PER_WORD + i)*FN_W +: FN_W];
            end

            AST_FN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
                wr_word[w] |=> word_rd[w*DATA_W +: DATA_W] == ($past(wr_data) & WMASK)); // R2
        end
    endgenerate

    AST_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_word)); // R2

endmodule

// File: rtl/gpio_out_latch.sv
// Output value store for all pads, changed only by bank-wide set and clear
// strobes. Assumes at most one bank strobe per cycle from the decoder; if a
// pad is both set and cleared in one cycle, clearing has priority.
module gpio_out_latch #(
    parameter int NUM_PINS  = 54,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] set_stb,
    input  logic [NUM_BANKS-1:0] clr_stb,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [NUM_PINS-1:0]  lat_q
);

    logic [NUM_PINS-1:0] set_vec;
    logic [NUM_PINS-1:0] clr_vec;

    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_mask
            assign set_vec[p] = set_stb[p / DATA_W] & wr_data[p % DATA_W];
            assign clr_vec[p] = clr_stb[p / DATA_W] & wr_data[p % DATA_W];
        end
    endgenerate

    // Apply set then clear, so clear wins on a shared pad.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else
            lat_q <= (lat_q | set_vec) & ~clr_vec;
    end

    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((lat_q & $past(set_vec & ~clr_vec)) == $past(set_vec & ~clr_vec))); // R4
    AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_vec) |=> ((lat_q & $past(clr_vec)) == '0)); // R5
    AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((lat_q ^ $past(lat_q)) & ~$past(set_vec | clr_vec)) == '0)); // R4

endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the pad inputs. Assumes pad_in may change at any
// time relative to clk; the second stage feeds the level registers.
module gpio_in_sync #(
    parameter int NUM_PINS = 54
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] sync_q
);

    logic [NUM_PINS-1:0] meta_q;

    // Shift the pad levels through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
        end
    end

    AST_TWO_EDGE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |=> (sync_q == $past(pad_in, 2))); // R6

endmodule

// File: rtl/gpio_bank_port.sv
// Banked GPIO port top: decodes the register bus, holds function codes and
// output values, synchronizes pad inputs and drives the pad-side controls.
// Assumes one bus access per cycle and combinational read data.
module gpio_bank_port
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS  = 54,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int PER_WORD  = 10,
    parameter int FN_BASE   = 'h00,
    parameter int SET_BASE  = 'h1C,
    parameter int CLR_BASE  = 'h28,
    parameter int LEV_BASE  = 'h34
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wen,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [NUM_PINS-1:0]      pad_in,
    output logic [NUM_PINS-1:0]      pad_out,
    output logic [NUM_PINS-1:0]      pad_oe,
    output logic [NUM_PINS-1:0]      pad_alt_en,
    output logic [NUM_PINS*FN_W-1:0] pad_alt_num
);

    localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;
    localparam int NUM_WORDS = (NUM_PINS + PER_WORD - 1) / PER_WORD;
    localparam int STEP      = DATA_W / 8;

    logic [NUM_WORDS-1:0]        hit_fn;
    logic [NUM_BANKS-1:0]        hit_set;
    logic [NUM_BANKS-1:0]        hit_clr;
    logic [NUM_BANKS-1:0]        hit_lev;
    logic [NUM_WORDS-1:0]        wr_fn;
    logic [NUM_BANKS-1:0]        wr_set;
    logic [NUM_BANKS-1:0]        wr_clr;
    logic [NUM_PINS*FN_W-1:0]    fn_flat;
    logic [NUM_WORDS*DATA_W-1:0] fn_words;
    logic [NUM_PINS-1:0]         lat_q;
    logic [NUM_PINS-1:0]         sync_q;
    logic [NUM_BANKS*DATA_W-1:0] lev_pad;

    // Match the bus address against every word of each register group.
    always_comb begin
        for (int k = 0; k < NUM_WORDS; k++)
            hit_fn[k] = (reg_addr == ADDR_W'(FN_BASE + k * STEP));
        for (int b = 0; b < NUM_BANKS; b++) begin
            hit_set[b] = (reg_addr == ADDR_W'(SET_BASE + b * STEP));
            hit_clr[b] = (reg_addr == ADDR_W'(CLR_BASE + b * STEP));
            hit_lev[b] = (reg_addr == ADDR_W'(LEV_BASE + b * STEP));
        end
    end

    assign wr_fn  = hit_fn  & {NUM_WORDS{reg_wen}};
    assign wr_set = hit_set & {NUM_BANKS{reg_wen}};
    assign wr_clr = hit_clr & {NUM_BANKS{reg_wen}};

    gpio_fn_regs #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W),
        .PER_WORD (PER_WORD),
        .NUM_WORDS(NUM_WORDS)
    ) u_fn (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_word(wr_fn),
        .wr_data(reg_wdata),
        .fn_flat(fn_flat),
        .word_rd(fn_words)
    );

    gpio_out_latch #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W),
        .NUM_BANKS(NUM_BANKS)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_stb(wr_set),
        .clr_stb(wr_clr),
        .wr_data(reg_wdata),
        .lat_q  (lat_q)
    );

    gpio_in_sync #(
        .NUM_PINS(NUM_PINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pad_in(pad_in),
        .sync_q(sync_q)
    );

    // Zero-extend the synchronized levels to whole bank words.
    always_comb begin
        lev_pad = '0;
        lev_pad[NUM_PINS-1:0] = sync_q;
    end

    // Select read data; write-only and unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_WORDS; k++)
            if (hit_fn[k])
                reg_rdata = fn_words[k*DATA_W +: DATA_W];
        for (int b = 0; b < NUM_BANKS; b++)
            if (hit_lev[b])
                reg_rdata = lev_pad[b*DATA_W +: DATA_W];
    end

    assign pad_out = lat_q;

    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_pad
            logic [FN_W-1:0] code;
            assign code                        = fn_flat[p*FN_W +: FN_W];
            assign pad_oe[p]                   = (code == FN_OUTPUT);
            assign pad_alt_en[p]               = fn_is_alt(code);
            assign pad_alt_num[p*FN_W +: FN_W] = fn_alt_slot(code);
        end
    endgenerate

    AST_OE_ALT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_alt_en) == '0); // R3
    AST_SLOT_ZERO_UNLESS_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_alt_en[0] |-> (pad_alt_num[FN_W-1:0] == '0)); // R3
    AST_LATCH_FN_INDEPENDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fn != '0) |=> $stable(pad_out)); // R7

endmodule

// File: tb/tb_gpio_bank_port.sv
// Self-checking bench: a behavioural model (arrays plus an input-history
// queue) predicts every output and the read data, compared each clock.
module tb_gpio_bank_port;

    localparam int NP = 54;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wen = 1'b0;
    logic [7:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NP-1:0]  pad_in = '0;
    logic [NP-1:0]  pad_out;
    logic [NP-1:0]  pad_oe;
    logic [NP-1:0]  pad_alt_en;
    logic [NP*3-1:0] pad_alt_num;

    int n_chk = 0;
    int n_fail = 0;
    bit chk_on = 0;
    bit done = 0;

    gpio_bank_port dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_alt_en(pad_alt_en),
        .pad_alt_num(pad_alt_num)
    );

    always #5 clk = ~clk;

    // Behavioural model state.
    logic [2:0]    fn_m [NP];
    bit            val_m [NP];
    logic [NP-1:0] hist [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin fn_m[p] = 3'd0; val_m[p] = 1'b0; end
            hist.delete();
        end else begin
            if (reg_wen) begin
                for (int w = 0; w < 6; w++)
                    if (reg_addr == 8'(w * 4))
                        for (int i = 0; i < 10; i++)
                            if (w * 10 + i < NP) fn_m[w*10+i] = reg_wdata[i*3 +: 3];
                for (int b = 0; b < 2; b++)
                    for (int i = 0; i < 32; i++)
                        if (b * 32 + i < NP && reg_wdata[i]) begin
                            if (reg_addr == 8'(8'h1C + b * 4)) val_m[b*32+i] = 1'b1;
                            if (reg_addr == 8'(8'h28 + b * 4)) val_m[b*32+i] = 1'b0;
                        end
            end
            hist.push_back(pad_in);
            if (hist.size() > 2) void'(hist.pop_front());
        end
    end

    function automatic logic [NP-1:0] lev_exp();
        return (hist.size() == 2) ? hist[0] : '0;
    endfunction

    function automatic logic [2:0] slot_exp(input logic [2:0] c);
        case (c)
            3'd4: return 3'd0; 3'd5: return 3'd1; 3'd6: return 3'd2;
            3'd7: return 3'd3; 3'd3: return 3'd4; 3'd2: return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [31:0] rd_exp(input logic [7:0] a);
        logic [31:0] r;
        logic [63:0] lv;
        r = '0;
        lv = 64'(lev_exp());
        for (int w = 0; w < 6; w++)
            if (a == 8'(w * 4))
                for (int i = 0; i < 10; i++)
                    if (w * 10 + i < NP) r[i*3 +: 3] = fn_m[w*10+i];
        if (a == 8'h34) r = lv[31:0];
        if (a == 8'h38) r = lv[63:32];
        return r;
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        if (a <= 8'h14 && a[1:0] == 2'b00) return "R2 fn readback";
        if (a == 8'h34 || a == 8'h38)      return "R6 level read";
        return "R8 write-only/unmapped read";
    endfunction

    function automatic logic [NP-1:0] out_exp();
        logic [NP-1:0] v;
        for (int p = 0; p < NP; p++) v[p] = val_m[p];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            logic [NP-1:0]   e_oe, e_alt;
            logic [NP*3-1:0] e_num;
            for (int p = 0; p < NP; p++) begin
                e_oe[p]          = (fn_m[p] == 3'd1);
                e_alt[p]         = (fn_m[p] >= 3'd2);
                e_num[p*3 +: 3]  = slot_exp(fn_m[p]);
            end
            chk("R7 pad_out", 256'(pad_out), 256'(out_exp()));
            chk("R3 pad_oe", 256'(pad_oe), 256'(e_oe));
            chk("R3 pad_alt_en", 256'(pad_alt_en), 256'(e_alt));
            chk("R3 pad_alt_num", 256'(pad_alt_num), 256'(e_num));
            chk(rd_tag(reg_addr), 256'(reg_rdata), 256'(rd_exp(reg_addr)));
        end
    end

    task automatic drive(input bit we, input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_wen = we; reg_addr = a; reg_wdata = d;
    endtask

    task automatic idle_at(input logic [7:0] a);
        drive(1'b0, a, 32'h0);
    endtask

    // Wait until the next sampling point after the last driven edge.
    task automatic settle();
        @(posedge clk); #2; reg_wen = 1'b0;
        @(negedge clk); #1;
    endtask

    initial begin : main
        pad_in = '0;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        chk_on = 1;
        // R1: reset state on the pads and in every function word.
        chk("R1 pad_out after reset", 256'(pad_out), 256'(0));
        chk("R1 pad_oe after reset", 256'(pad_oe), 256'(0));
        chk("R1 pad_alt_en after reset", 256'(pad_alt_en), 256'(0));
        chk("R1 pad_alt_num after reset", 256'(pad_alt_num), 256'(0));
        for (int w = 0; w < 6; w++) begin
            idle_at(8'(w * 4));
            @(negedge clk); #1;
            chk("R1 fn word after reset", 256'(reg_rdata), 256'(0));
        end

        // R2/R3: every code in word 0, all-ones into partial word 5.
        drive(1'b1, 8'h00, {2'b11, 3'd1, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0});
        drive(1'b1, 8'h14, 32'hFFFF_FFFF);
        idle_at(8'h14);
        @(negedge clk); #1;
        chk("R2 partial word upper fields zero", 256'(reg_rdata), 256'(32'h0000_0FFF));
        chk("R3 slot map pad 2", 256'(pad_alt_num[2*3 +: 3]), 256'(3'd5));
        chk("R3 slot map pad 3", 256'(pad_alt_num[3*3 +: 3]), 256'(3'd4));
        chk("R3 oe pad 1", 256'(pad_oe[1]), 256'(1));

        // R7: stage pad 12 high while input, then switch it to output.
        drive(1'b1, 8'h1C, 32'h0000_1000);
        settle();
        chk("R7 staged value visible", 256'(pad_out[12]), 256'(1));
        chk("R7 oe still low", 256'(pad_oe[12]), 256'(0));
        drive(1'b1, 8'h04, 32'h0000_0040);
        settle();
        chk("R7 oe after switch", 256'(pad_oe[12]), 256'(1));
        chk("R7 value held across switch", 256'(pad_out[12]), 256'(1));

        // R4/R5: bank-wise set and clear patterns, including bits past pad 53.
        drive(1'b1, 8'h1C, 32'hA5A5_5A5A);
        drive(1'b1, 8'h20, 32'hFFFF_FFFF);
        settle();
        chk("R4 set bank0", 256'(pad_out[31:0]), 256'(32'hA5A5_5A5A | 32'h0000_1000));
        chk("R4 set bank1", 256'(pad_out[53:32]), 256'(22'h3F_FFFF));
        drive(1'b1, 8'h28, 32'h0000_FFFF);
        drive(1'b1, 8'h2C, 32'h0015_5555);
        settle();
        chk("R5 clear bank0", 256'(pad_out[31:0]), 256'(32'hA5A5_0000));
        chk("R5 clear bank1", 256'(pad_out[53:32]), 256'(22'h2A_AAAA));

        // R8: writes to level and unmapped addresses change nothing.
        drive(1'b1, 8'h34, 32'hFFFF_FFFF);
        drive(1'b1, 8'h40, 32'hFFFF_FFFF);
        drive(1'b1, 8'h1E, 32'hFFFF_FFFF);
        drive(1'b1, 8'h18, 32'hFFFF_FFFF);
        settle();
        chk("R8 outputs unchanged", 256'(pad_out[31:0]), 256'(32'hA5A5_0000));
        idle_at(8'h1C);
        @(negedge clk); #1;
        chk("R8 set reg reads zero", 256'(reg_rdata), 256'(0));

        // R6: level read follows pad_in two edges later; bank1 top bits zero.
        idle_at(8'h38);
        pad_in = '1;
        @(negedge clk); #1;
        chk("R6 not yet visible", 256'(reg_rdata), 256'(0));
        @(negedge clk); #1;
        @(negedge clk); #1;
        chk("R6 bank1 level", 256'(reg_rdata), 256'(32'h003F_FFFF));

        // Random traffic across mapped and unmapped addresses.
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] pick;
            case ($urandom_range(0, 12))
                0, 1, 2: pick = 8'(4 * $urandom_range(0, 5));
                3:  pick = 8'h1C;  4: pick = 8'h20;
                5:  pick = 8'h28;  6: pick = 8'h2C;
                7, 8: pick = 8'h34; 9, 10: pick = 8'h38;
                default: pick = 8'($urandom_range(0, 255));
            endcase
            drive(1'($urandom_range(0, 1)), pick, $urandom);
            pad_in = {22'($urandom), 32'($urandom)};
        end
        settle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule